// File: doc/BRIEF.md
# Serially Loaded DDS Control Register

This block is the receiving side of a direct digital synthesis core's control interface. An external controller drives a word clock, a data bus and an update strobe. The block turns those into three held settings: a 32-bit tuning word, a 5-bit phase offset and a power-down flag. Phase accumulation and sine lookup sit downstream and are not part of this block.

After power-up the block is in parallel mode. In that mode the only thing it acts on is the serial-enable handshake. A 3-bit code is presented on the low data lines and clocked in by exactly one word-clock pulse, and an update strobe then commits it. Once in serial mode, each word-clock rise shifts in one bit from the top data line, least significant bit first. A 40-bit word is applied to the outputs only when the update strobe arrives after exactly 40 bits and the two reserved bits are zero. Malformed commits raise sticky error flags and leave the outputs alone.

All external inputs are brought into the reference clock domain through a synchroniser chain, and their edges are found there. A separate device reset input acts only after it has been held for a minimum number of reference cycles. A fixed busy window follows its release.

Top module: `dds_ctrl_rx`

## Requirements
- R1: While rst_ni is low, and right after it rises, tuning_o, phase_o, pwrdn_o, serial_o, frame_err_o and test_err_o are all 0 and ready_o is 1.
- R2: A dev_rst_i level seen high for HOLD_MIN (5) consecutive synchronised cycles clears the tuning word, phase, power-down, both error flags and serial mode. A shorter high pulse changes nothing.
- R3: After an effective device reset is released, ready_o stays low for LATENCY (13) cycles. Word-clock and strobe events in that window, or while dev_rst_i is high, are ignored.
- R4: Serial mode is entered only when an update strobe follows exactly one word-clock rise in parallel mode with data_i[2:0] = 3'b011 (bit 0 = 1, bit 1 = 1, bit 2 = 0). Other codes, or other pulse counts, leave serial_o at 0.
- R5: In serial mode each word-clock rise captures data_i[7]. The first bit captured becomes word bit 0.
- R6: Word bits 31..0 drive tuning_o, bit 34 drives pwrdn_o, and bits 39..35 drive phase_o with bit 35 as its LSB.
- R7: tuning_o, phase_o and pwrdn_o change only on an update strobe rise or a device reset, never on the word clock alone.
- R8: A strobe after 40 bits with word bits 33..32 nonzero sets test_err_o and leaves the outputs unchanged.
- R9: A strobe after fewer or more than 40 bits sets frame_err_o and leaves the outputs unchanged.
- R10: Every strobe in serial mode restarts the bit count, so the next word needs 40 fresh bits.
- R11: An input change takes effect at the outputs on the third rising clk_i edge after it is presented (two synchroniser stages plus one edge register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| dev_rst_i | input | 1 | Device reset request, active high, asynchronous to clk_i |
| wclk_i | input | 1 | Word clock, rising edge captures data |
| data_i | input | DATA_W | Data bus: [2:0] carries the mode code, [DATA_W-1] carries serial data |
| strobe_i | input | 1 | Update strobe, rising edge commits |
| tuning_o | output | 32 | Active frequency tuning word |
| phase_o | output | 5 | Active phase offset code |
| pwrdn_o | output | 1 | Active power-down flag |
| serial_o | output | 1 | High once serial mode is entered |
| ready_o | output | 1 | Low during an effective device reset and its busy window |
| frame_err_o | output | 1 | Sticky: commit with a bit count other than 40 |
| test_err_o | output | 1 | Sticky: commit with reserved bits set |

## Verification
The bench builds the block with its default parameters: an 8-bit data bus, two synchroniser stages, a 5-cycle reset hold and a 13-cycle busy window. These short windows let the bench drive a 3-cycle reset pulse that must be ignored and an 8-cycle pulse that must act. They also let it place a word-clock pulse inside the busy window and confirm that the pulse is dropped, all within a few hundred cycles. Word lengths of 39, 40 and 41 bits and a word with a reserved bit set cover the edges of the commit rule.

// File: rtl/dds_rx_pkg.sv
package dds_rx_pkg;
  localparam int WORD_W  = 40;
  localparam int TUNE_W  = 32;
  localparam int PHASE_W = 5;
  localparam int RSV_LSB = 32;
  localparam int RSV_W   = 2;
  localparam int PD_POS  = 34;
  localparam int PH_LSB  = 35;
  localparam int CODE_W  = 3;

  // bit0=1, bit1=1, bit2=0
  localparam logic [CODE_W-1:0] SER_EN_CODE = 3'b011;

  typedef struct packed {
    logic [PHASE_W-1:0] phase;
    logic               pwrdn;
    logic [TUNE_W-1:0]  tuning;
  } dds_cfg_t;
endpackage

// File: rtl/dds_in_sync.sv
module dds_in_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign q_o    = stg_q[STAGES-1];
  assign rise_o = q_o & ~prev_q;
endmodule

// File: rtl/dds_rst_ctrl.sv
module dds_rst_ctrl #(
  parameter int HOLD_MIN = 5,
  parameter int LATENCY  = 13
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dev_rst_i,
  output logic clear_o,
  output logic accept_o,
  output logic ready_o
);
  localparam int HW = $clog2(HOLD_MIN + 1);
  localparam int LW = $clog2(LATENCY + 1);

  logic [HW-1:0] hcnt_q, hold_next;
  logic [LW-1:0] lat_q;
  logic          armed_q;

  assign hold_next = (hcnt_q == HW'(HOLD_MIN)) ? hcnt_q : hcnt_q + 1'b1;
  assign clear_o   = dev_rst_i && (hold_next == HW'(HOLD_MIN));
  assign ready_o   = !armed_q && (lat_q == '0);
  assign accept_o  = !dev_rst_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q  <= '0;
      lat_q   <= '0;
      armed_q <= 1'b0;
    end else if (dev_rst_i) begin
      hcnt_q <= hold_next;
      if (hold_next == HW'(HOLD_MIN)) armed_q <= 1'b1;
    end else begin
      hcnt_q <= '0;
      if (armed_q) begin
        armed_q <= 1'b0;
        lat_q   <= LW'(LATENCY);
      end else if (lat_q != '0) begin
        lat_q <= lat_q - 1'b1;
      end
    end
  end

  p_busy_after_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !dev_rst_i) |=> !ready_o);
endmodule

// File: rtl/dds_ser_core.sv
module dds_ser_core
  import dds_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              accept_i,
  input  logic              wclk_rise_i,
  input  logic              strobe_rise_i,
  input  logic              ser_bit_i,
  input  logic [CODE_W-1:0] par_i,
  output dds_cfg_t          cfg_o,
  output logic              serial_o,
  output logic              frame_err_o,
  output logic              test_err_o
);
  localparam int CW = $clog2(WORD_W + 2);

  logic [WORD_W-1:0] sreg_q;
  logic [CW-1:0]     bcnt_q;
  logic [CODE_W-1:0] par_q;
  logic [1:0]        pcnt_q;
  logic              serial_q, ferr_q, terr_q;
  dds_cfg_t          cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q   <= '0;
      bcnt_q   <= '0;
      par_q    <= '0;
      pcnt_q   <= '0;
      serial_q <= 1'b0;
      ferr_q   <= 1'b0;
      terr_q   <= 1'b0;
      cfg_q    <= '0;
    end else if (clear_i) begin
      sreg_q   <= '0;
      bcnt_q   <= '0;
      par_q    <= '0;
      pcnt_q   <= '0;
      serial_q <= 1'b0;
      ferr_q   <= 1'b0;
      terr_q   <= 1'b0;
      cfg_q    <= '0;
    end else if (accept_i) begin
      if (strobe_rise_i) begin
        if (serial_q) begin
          if (bcnt_q == CW'(WORD_W)) begin
            if (sreg_q[RSV_LSB +: RSV_W] != '0) begin
              terr_q <= 1'b1;
            end else begin
              cfg_q.tuning <= sreg_q[TUNE_W-1:0];
              cfg_q.pwrdn  <= sreg_q[PD_POS];
              cfg_q.phase  <= sreg_q[PH_LSB +: PHASE_W];
            end
          end else begin
            ferr_q <= 1'b1;
          end
          bcnt_q <= '0;
        end else begin
          if (pcnt_q == 2'd1 && par_q == SER_EN_CODE) serial_q <= 1'b1;
          pcnt_q <= '0;
        end
      end else if (wclk_rise_i) begin
        if (serial_q) begin
          // LSB first: after 40 shifts the first bit sits at bit 0
          sreg_q <= {ser_bit_i, sreg_q[WORD_W-1:1]};
          if (bcnt_q != CW'(WORD_W + 1)) bcnt_q <= bcnt_q + 1'b1;
        end else begin
          par_q <= par_i;
          if (pcnt_q != 2'd2) pcnt_q <= pcnt_q + 1'b1;
        end
      end
    end
  end

  assign cfg_o       = cfg_q;
  assign serial_o    = serial_q;
  assign frame_err_o = ferr_q;
  assign test_err_o  = terr_q;

  p_cfg_on_commit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_o) |-> ($past(strobe_rise_i) || $past(clear_i)));
  p_serial_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(serial_o) |-> ($past(strobe_rise_i) && $past(accept_i)));
  p_test_err_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(test_err_o) |-> $stable(cfg_o));
  p_frame_err_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_err_o) |-> $stable(cfg_o));
endmodule

// File: rtl/dds_ctrl_rx.sv
module dds_ctrl_rx
  import dds_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SER_LANE    = DATA_W - 1,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_MIN    = 5,
  parameter int LATENCY     = 13
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dev_rst_i,
  input  logic               wclk_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic               strobe_i,
  output logic [TUNE_W-1:0]  tuning_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic               pwrdn_o,
  output logic               serial_o,
  output logic               ready_o,
  output logic               frame_err_o,
  output logic               test_err_o
);
  localparam int SW     = DATA_W + 3;
  localparam int WC_POS = DATA_W;
  localparam int SB_POS = DATA_W + 1;
  localparam int RS_POS = DATA_W + 2;

  logic [SW-1:0] s_q, s_rise;
  logic          clear, accept;
  dds_cfg_t      cfg;
  logic          unused_ok;

  dds_in_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({dev_rst_i, strobe_i, wclk_i, data_i}),
    .q_o    (s_q),
    .rise_o (s_rise)
  );

  dds_rst_ctrl #(.HOLD_MIN(HOLD_MIN), .LATENCY(LATENCY)) u_rst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dev_rst_i (s_q[RS_POS]),
    .clear_o   (clear),
    .accept_o  (accept),
    .ready_o   (ready_o)
  );

  dds_ser_core u_core (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clear_i       (clear),
    .accept_i      (accept),
    .wclk_rise_i   (s_rise[WC_POS]),
    .strobe_rise_i (s_rise[SB_POS]),
    .ser_bit_i     (s_q[SER_LANE]),
    .par_i         (s_q[CODE_W-1:0]),
    .cfg_o         (cfg),
    .serial_o      (serial_o),
    .frame_err_o   (frame_err_o),
    .test_err_o    (test_err_o)
  );

  assign unused_ok = ^{s_rise[DATA_W-1:0], s_rise[RS_POS], s_q[SB_POS:WC_POS], s_q[DATA_W-1:0]};

  assign tuning_o = cfg.tuning;
  assign phase_o  = cfg.phase;
  assign pwrdn_o  = cfg.pwrdn;

  p_clear_state_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear |=> (tuning_o == '0 && phase_o == '0 && !pwrdn_o && !serial_o
               && !frame_err_o && !test_err_o));
  p_busy_ignore_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !clear) |=> ($stable(tuning_o) && $stable(serial_o) && $stable(frame_err_o)));
endmodule

// File: tb/dds_ctrl_rx_bench.sv
module dds_ctrl_rx_bench;
  localparam int HOLD = 5;
  localparam int LAT  = 13;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dev_rst_i = 1'b0;
  logic        wclk_i = 1'b0;
  logic [7:0]  data_i = '0;
  logic        strobe_i = 1'b0;
  logic [31:0] tuning_o;
  logic [4:0]  phase_o;
  logic        pwrdn_o, serial_o, ready_o, frame_err_o, test_err_o;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  bit done    = 0;

  always #10 clk_i = ~clk_i;

  dds_ctrl_rx u_dds_ctrl_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .dev_rst_i(dev_rst_i), .wclk_i(wclk_i),
    .data_i(data_i), .strobe_i(strobe_i), .tuning_o(tuning_o), .phase_o(phase_o),
    .pwrdn_o(pwrdn_o), .serial_o(serial_o), .ready_o(ready_o),
    .frame_err_o(frame_err_o), .test_err_o(test_err_o)
  );

  // behavioural reference model
  bit         hw[4], hs[4], hr[4];
  logic [7:0] hd[4];
  bit         m_serial, m_ferr, m_terr, m_pd, m_armed;
  logic [39:0] m_word;
  logic [31:0] m_tw;
  logic [4:0]  m_ph;
  logic [2:0]  m_par;
  int m_bits, m_pc, m_hc, m_lat;
  bit rr, wr, sr;

  task automatic model_clear();
    m_serial = 0; m_ferr = 0; m_terr = 0; m_pd = 0;
    m_word = '0; m_tw = '0; m_ph = '0; m_par = '0; m_bits = 0; m_pc = 0;
  endtask

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int i = 0; i < 4; i++) begin hw[i] = 0; hs[i] = 0; hr[i] = 0; hd[i] = '0; end
      model_clear();
      m_armed = 0; m_hc = 0; m_lat = 0;
    end else begin
      for (int i = 3; i > 0; i--) begin
        hw[i] = hw[i-1]; hs[i] = hs[i-1]; hr[i] = hr[i-1]; hd[i] = hd[i-1];
      end
      hw[0] = wclk_i; hs[0] = strobe_i; hr[0] = dev_rst_i; hd[0] = data_i;
      rr = hr[2]; wr = hw[2] && !hw[3]; sr = hs[2] && !hs[3];
      if (rr) begin
        if (m_hc < HOLD) m_hc++;
        if (m_hc >= HOLD) begin model_clear(); m_armed = 1; end
      end else begin
        m_hc = 0;
        if (m_armed) begin m_armed = 0; m_lat = LAT; end
        else if (m_lat > 0) m_lat--;
        else if (sr) begin
          if (m_serial) begin
            if (m_bits == 40) begin
              if (m_word[33:32] != 0) m_terr = 1;
              else begin m_tw = m_word[31:0]; m_pd = m_word[34]; m_ph = m_word[39:35]; end
            end else m_ferr = 1;
            m_bits = 0;
          end else begin
            if (m_pc == 1 && m_par == 3'b011) m_serial = 1;
            m_pc = 0;
          end
        end else if (wr) begin
          if (m_serial) begin
            if (m_bits < 40) m_word[m_bits] = hd[2][7];
            if (m_bits < 41) m_bits++;
          end else begin
            m_par = hd[2][2:0];
            if (m_pc < 2) m_pc++;
          end
        end
      end
    end
  end

  // per-cycle compare (R11 timing) and watchdog
  always @(negedge clk_i) begin
    cyc++;
    if (rst_ni && !done) begin
      vectors++;
      if ({tuning_o, phase_o, pwrdn_o, serial_o, ready_o, frame_err_o, test_err_o} !==
          {m_tw, m_ph, m_pd, m_serial, (!m_armed && m_lat == 0), m_ferr, m_terr}) begin
        fails++;
        $display("FAIL R11 cyc %0d act=%h/%h/%b/%b/%b/%b/%b exp=%h/%h/%b/%b/%b/%b/%b", cyc,
                 tuning_o, phase_o, pwrdn_o, serial_o, ready_o, frame_err_o, test_err_o,
                 m_tw, m_ph, m_pd, m_serial, (!m_armed && m_lat == 0), m_ferr, m_terr);
      end
    end
    if (cyc > 50000 && !done) begin
      fails++;
      done = 1;
      $display("FAIL watchdog act=%0d exp<=50000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wpulse(input logic [7:0] d);
    data_i = d; step(2);
    wclk_i = 1'b1; step(2);
    wclk_i = 1'b0; step(1);
  endtask

  task automatic strobe();
    step(1); strobe_i = 1'b1; step(2); strobe_i = 1'b0; step(4);
  endtask

  task automatic send_bits(input logic [39:0] w, input int n);
    for (int i = 0; i < n; i++) wpulse({(i < 40) ? w[i] : 1'b0, 7'b0});
  endtask

  function automatic logic [39:0] mk(input logic [31:0] tw, input logic pd,
                                     input logic [4:0] ph, input logic [1:0] rsv);
    return {ph, pd, rsv, tw};
  endfunction

  function automatic logic [63:0] outs();
    return {19'b0, tuning_o, phase_o, pwrdn_o, serial_o, ready_o, frame_err_o, test_err_o};
  endfunction

  function automatic logic [63:0] pack(input logic [31:0] tw, input logic [4:0] ph,
                                       input logic pd, input logic ser, input logic rdy,
                                       input logic fe, input logic te);
    return {19'b0, tw, ph, pd, ser, rdy, fe, te};
  endfunction

  initial begin
    step(3);
    chk("R1 in reset", outs(), pack(32'h0, 5'h0, 0, 0, 1, 0, 0));
    rst_ni = 1'b1;
    step(3);
    chk("R1 after reset", outs(), pack(32'h0, 5'h0, 0, 0, 1, 0, 0));

    // R4: wrong code
    wpulse(8'h07); strobe();
    chk("R4 wrong code", {63'b0, serial_o}, 64'd0);
    // R4: right code but two pulses
    wpulse(8'h03); wpulse(8'h03); strobe();
    chk("R4 two pulses", {63'b0, serial_o}, 64'd0);
    // R4: right code, one pulse
    wpulse(8'h03); strobe();
    chk("R4 serial enable", {63'b0, serial_o}, 64'd1);

    // R7: bits shifted but no strobe
    send_bits(mk(32'h12345678, 1'b0, 5'h15, 2'b00), 40);
    chk("R7 no strobe no change", outs(), pack(32'h0, 5'h0, 0, 1, 1, 0, 0));
    strobe();
    chk("R5 R6 word one", outs(), pack(32'h12345678, 5'h15, 0, 1, 1, 0, 0));

    send_bits(mk(32'hA5A5F00F, 1'b1, 5'h1F, 2'b00), 40); strobe();
    chk("R6 word two", outs(), pack(32'hA5A5F00F, 5'h1F, 1, 1, 1, 0, 0));

    // R9: short word
    send_bits(mk(32'h0000FFFF, 1'b0, 5'h01, 2'b00), 39); strobe();
    chk("R9 short word", outs(), pack(32'hA5A5F00F, 5'h1F, 1, 1, 1, 1, 0));
    // R10: count restarts after the failed commit
    send_bits(mk(32'h80000001, 1'b0, 5'h02, 2'b00), 40); strobe();
    chk("R10 restart", outs(), pack(32'h80000001, 5'h02, 0, 1, 1, 1, 0));
    // R9: long word
    send_bits(mk(32'h11111111, 1'b1, 5'h03, 2'b00), 41); strobe();
    chk("R9 long word", outs(), pack(32'h80000001, 5'h02, 0, 1, 1, 1, 0));
    // R8: reserved bit set
    send_bits(mk(32'h22222222, 1'b1, 5'h04, 2'b01), 40); strobe();
    chk("R8 reserved bit", outs(), pack(32'h80000001, 5'h02, 0, 1, 1, 1, 1));

    // R2: short device reset has no effect
    dev_rst_i = 1'b1; step(3); dev_rst_i = 1'b0; step(6);
    chk("R2 short pulse", outs(), pack(32'h80000001, 5'h02, 0, 1, 1, 1, 1));
    // R2: long device reset clears
    dev_rst_i = 1'b1; step(8); dev_rst_i = 1'b0; step(2);
    chk("R2 long pulse", outs(), pack(32'h0, 5'h0, 0, 0, 0, 0, 0));
    chk("R3 busy after release", {63'b0, ready_o}, 64'd0);
    // R3: word clock during busy window is dropped
    data_i = 8'h03; wclk_i = 1'b1; step(1); wclk_i = 1'b0; step(20);
    chk("R3 ready again", {63'b0, ready_o}, 64'd1);
    strobe();
    chk("R3 busy pulse ignored", {63'b0, serial_o}, 64'd0);

    // back to serial after reset
    wpulse(8'h03); strobe();
    chk("R4 re-enable", {63'b0, serial_o}, 64'd1);
    send_bits(mk(32'hDEADBEEF, 1'b1, 5'h0A, 2'b00), 40); strobe();
    chk("R6 after reset", outs(), pack(32'hDEADBEEF, 5'h0A, 1, 1, 1, 0, 0));

    step(5);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule